// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries a single 36-bit word from a sending clock domain to a receiving clock domain without going through FIFO storage. The sender writes the word under its own clock by pulsing a write strobe with its mailbox-select input high. An active-low mail flag in the receiving domain then drops to announce that a word is waiting. The receiver reads the word by setting its own mailbox-select input. That input also steers the read-side output multiplexer between the mailbox and the FIFO output register, which is supplied from outside the block.

Only one word can be in flight at a time. After a write is accepted, the mailbox refuses further writes until the receiver has acknowledged the word with a mailbox read. Write and acknowledge events cross the clock boundary as toggles, each through a multi-flop synchronizer. The sender has its own view of the flag, so it can tell when the mailbox is free again. The stored word stays in place until the next accepted write; reading it does not clear it.

Top module: `mbox_bypass`

## Requirements
- R1: After reset, `rcv_mail_n_o` and `snd_mail_n_o` are 1 and the mailbox holds all zeros.
- R2: A sender clock edge with `snd_wr_i`=1, `snd_mb_sel_i`=1 and `snd_mail_n_o`=1 stores `snd_data_i` in the mailbox. It drives `snd_mail_n_o` to 0 on that edge, and `rcv_mail_n_o` goes to 0 within a few receiver cycles.
- R3: A sender write with `snd_mb_sel_i`=0 leaves the mailbox contents and both flags unchanged.
- R4: While `snd_mail_n_o` is 0, sender writes are ignored and the mailbox keeps the first word.
- R5: A receiver clock edge with `rcv_rd_i`=1, `rcv_mb_sel_i`=1 and `rcv_mail_n_o`=0 returns `rcv_mail_n_o` to 1 on that edge. `snd_mail_n_o` then returns to 1 within a few sender cycles.
- R6: A receiver read with `rcv_mb_sel_i`=0 does not change `rcv_mail_n_o`.
- R7: `rcv_data_o` equals the mailbox contents when `rcv_mb_sel_i`=1 and equals `rcv_fifo_q_i` when `rcv_mb_sel_i`=0.
- R8: A mailbox read does not alter the stored word; it stays until the next accepted write.
- R9: Asserting `rst_ni` while mail is pending forces `rcv_mail_n_o` and `snd_mail_n_o` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_snd_i | input | 1 | Sending domain clock |
| clk_rcv_i | input | 1 | Receiving domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| snd_wr_i | input | 1 | Sender write strobe |
| snd_mb_sel_i | input | 1 | Sender mailbox select |
| snd_data_i | input | 36 | Word to place in the mailbox |
| snd_mail_n_o | output | 1 | Sender view of mail flag, 0 = mailbox occupied |
| rcv_rd_i | input | 1 | Receiver read strobe |
| rcv_mb_sel_i | input | 1 | Receiver mailbox select, also output mux select |
| rcv_fifo_q_i | input | 36 | FIFO output register contents |
| rcv_data_o | output | 36 | Read data: mailbox or FIFO output register |
| rcv_mail_n_o | output | 1 | Receiver mail flag, 0 = new mail |

## Verification
The handshake is exercised in four patterns: a write with the select low, an accepted write, a second write made while mail is still unread, and a full write/read/write round trip. Together they separate a missing select gate from a missing inhibit and from a stuck acknowledge. Reads are tried with the select both low and high. This shows that only a mailbox read clears the flag and that the stored word survives the clearing read. The output mux is checked with FIFO data that differs from the mailbox word. A reset applied while mail is pending confirms that the flag is forced high in both domains.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_DW_DEF   = 36;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = mbox_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/mbox_send.sv
module mbox_send #(
  parameter int unsigned DW         = mbox_pkg::MBOX_DW_DEF,
  parameter int unsigned SYNC_DEPTH = mbox_pkg::SYNC_DEPTH_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [DW-1:0] data_i,
  input  logic          ack_tog_i,
  output logic          wr_tog_o,
  output logic [DW-1:0] mbox_o,
  output logic          mail_n_o
);
  logic          ack_sync;
  logic          wr_tog_q;
  logic [DW-1:0] mbox_q;
  logic          free;
  logic          accept;

  mbox_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tog_i),
    .q_o   (ack_sync)
  );

  // mailbox is free once every issued write toggle has been acknowledged
  assign free   = (wr_tog_q == ack_sync);
  assign accept = wr_i & sel_i & free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tog_q <= 1'b0;
      mbox_q   <= '0;
    end else if (accept) begin
      wr_tog_q <= ~wr_tog_q;
      mbox_q   <= data_i;
    end
  end

  assign wr_tog_o = wr_tog_q;
  assign mbox_o   = mbox_q;
  assign mail_n_o = free;

  p_write_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mail_n_o |=> $stable(mbox_o));

  p_nosel_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(mbox_o));

  p_sender_view_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i && mail_n_o) |=> !mail_n_o);
endmodule

// File: rtl/mbox_recv.sv
module mbox_recv #(
  parameter int unsigned DW         = mbox_pkg::MBOX_DW_DEF,
  parameter int unsigned SYNC_DEPTH = mbox_pkg::SYNC_DEPTH_DEF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          sel_i,
  input  logic [DW-1:0] fifo_q_i,
  input  logic [DW-1:0] mbox_i,
  input  logic          wr_tog_i,
  output logic          ack_tog_o,
  output logic [DW-1:0] data_o,
  output logic          mail_n_o
);
  logic wr_sync;
  logic ack_tog_q;
  logic clear;

  mbox_sync #(.STAGES(SYNC_DEPTH)) u_wr_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_tog_i),
    .q_o   (wr_sync)
  );

  assign mail_n_o = (wr_sync == ack_tog_q);
  assign clear    = rd_i & sel_i & ~mail_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ack_tog_q <= 1'b0;
    else if (clear) ack_tog_q <= ~ack_tog_q;
  end

  assign ack_tog_o = ack_tog_q;
  assign data_o    = sel_i ? mbox_i : fifo_q_i;

  p_clear_on_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i && !mail_n_o) |=> mail_n_o);

  p_fifo_read_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !sel_i && !mail_n_o) |=> !mail_n_o);

  p_flag_fall_by_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mail_n_o) |-> !$stable(wr_sync));
endmodule

// File: rtl/mbox_bypass.sv
module mbox_bypass #(
  parameter int unsigned DW         = mbox_pkg::MBOX_DW_DEF,
  parameter int unsigned SYNC_DEPTH = mbox_pkg::SYNC_DEPTH_DEF
) (
  input  logic          clk_snd_i,
  input  logic          clk_rcv_i,
  input  logic          rst_ni,
  input  logic          snd_wr_i,
  input  logic          snd_mb_sel_i,
  input  logic [DW-1:0] snd_data_i,
  output logic          snd_mail_n_o,
  input  logic          rcv_rd_i,
  input  logic          rcv_mb_sel_i,
  input  logic [DW-1:0] rcv_fifo_q_i,
  output logic [DW-1:0] rcv_data_o,
  output logic          rcv_mail_n_o
);
  logic          wr_tog;
  logic          ack_tog;
  logic [DW-1:0] mbox;

  mbox_send #(.DW(DW), .SYNC_DEPTH(SYNC_DEPTH)) u_send (
    .clk_i    (clk_snd_i),
    .rst_ni   (rst_ni),
    .wr_i     (snd_wr_i),
    .sel_i    (snd_mb_sel_i),
    .data_i   (snd_data_i),
    .ack_tog_i(ack_tog),
    .wr_tog_o (wr_tog),
    .mbox_o   (mbox),
    .mail_n_o (snd_mail_n_o)
  );

  mbox_recv #(.DW(DW), .SYNC_DEPTH(SYNC_DEPTH)) u_recv (
    .clk_i    (clk_rcv_i),
    .rst_ni   (rst_ni),
    .rd_i     (rcv_rd_i),
    .sel_i    (rcv_mb_sel_i),
    .fifo_q_i (rcv_fifo_q_i),
    .mbox_i   (mbox),
    .wr_tog_i (wr_tog),
    .ack_tog_o(ack_tog),
    .data_o   (rcv_data_o),
    .mail_n_o (rcv_mail_n_o)
  );
endmodule

// File: tb/tb_mbox_bypass.sv
module tb_mbox_bypass;
  localparam int DW = 36;

  logic          clk_snd = 1'b0;
  logic          clk_rcv = 1'b0;
  logic          rst_ni  = 1'b0;
  logic          snd_wr = 1'b0, snd_sel = 1'b0;
  logic [DW-1:0] snd_data = '0;
  logic          snd_mail_n;
  logic          rcv_rd = 1'b0, rcv_sel = 1'b0;
  logic [DW-1:0] fifo_q = '0;
  logic [DW-1:0] rcv_data;
  logic          rcv_mail_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk_snd = ~clk_snd;
  initial begin
    #1;
    forever #2 clk_rcv = ~clk_rcv;
  end

  mbox_bypass dut (
    .clk_snd_i   (clk_snd),
    .clk_rcv_i   (clk_rcv),
    .rst_ni      (rst_ni),
    .snd_wr_i    (snd_wr),
    .snd_mb_sel_i(snd_sel),
    .snd_data_i  (snd_data),
    .snd_mail_n_o(snd_mail_n),
    .rcv_rd_i    (rcv_rd),
    .rcv_mb_sel_i(rcv_sel),
    .rcv_fifo_q_i(fifo_q),
    .rcv_data_o  (rcv_data),
    .rcv_mail_n_o(rcv_mail_n)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_snd);
  endtask

  task automatic snd_write(input logic sel, input logic [DW-1:0] d);
    @(negedge clk_snd);
    snd_wr = 1'b1; snd_sel = sel; snd_data = d;
    @(negedge clk_snd);
    snd_wr = 1'b0; snd_sel = 1'b0;
  endtask

  task automatic rcv_read(input logic sel);
    @(negedge clk_rcv);
    rcv_rd = 1'b1; rcv_sel = sel;
    @(negedge clk_rcv);
    rcv_rd = 1'b0;
  endtask

  task automatic peek_mbox(output logic [DW-1:0] v);
    @(negedge clk_rcv);
    rcv_sel = 1'b1;
    #0.5 v = rcv_data;
    rcv_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    check("R1 rcv flag", rcv_mail_n, 1);
    check("R1 snd flag", snd_mail_n, 1);
    peek_mbox(v);
    check("R1 mailbox zero", v, '0);
  endtask

  task automatic t_mux;
    fifo_q = 36'h9_1234_5678;
    @(negedge clk_rcv); rcv_sel = 1'b0;
    #0.5 check("R7 fifo path", rcv_data, 36'h9_1234_5678);
    rcv_sel = 1'b1;
    #0.5 check("R7 mailbox path", rcv_data, '0);
    rcv_sel = 1'b0;
  endtask

  task automatic t_nosel_write;
    logic [DW-1:0] v;
    snd_write(1'b0, 36'hA_AAAA_AAAA);
    idle(8);
    check("R3 rcv flag high", rcv_mail_n, 1);
    check("R3 snd flag high", snd_mail_n, 1);
    peek_mbox(v);
    check("R3 mailbox unchanged", v, '0);
  endtask

  task automatic t_write(input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] v;
    snd_write(1'b1, d);
    check({tag, " snd view low"}, snd_mail_n, 0);
    idle(8);
    check({tag, " rcv flag low"}, rcv_mail_n, 0);
    peek_mbox(v);
    check({tag, " mailbox word"}, v, d);
  endtask

  task automatic t_blocked;
    logic [DW-1:0] v;
    snd_write(1'b1, 36'h5_5555_5555);
    idle(8);
    peek_mbox(v);
    check("R4 first word kept", v, 36'h1_0203_0405);
    check("R4 flag still low", rcv_mail_n, 0);
  endtask

  task automatic t_rd_nosel;
    rcv_read(1'b0);
    idle(4);
    check("R6 flag stays low", rcv_mail_n, 0);
  endtask

  task automatic t_read;
    logic [DW-1:0] v;
    rcv_read(1'b1);
    check("R5 rcv flag high", rcv_mail_n, 1);
    idle(8);
    check("R5 snd flag high", snd_mail_n, 1);
    peek_mbox(v);
    check("R8 word kept after read", v, 36'h1_0203_0405);
  endtask

  task automatic t_reset_pending;
    @(negedge clk_snd);
    rst_ni = 1'b0;
    idle(2);
    check("R9 rcv flag forced high", rcv_mail_n, 1);
    check("R9 snd flag forced high", snd_mail_n, 1);
    rst_ni = 1'b1;
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_mux();
    t_nosel_write();
    t_write(36'h1_0203_0405, "R2 first");
    t_blocked();
    t_rd_nosel();
    t_read();
    t_write(36'hF_EDCB_A987, "R2 second");
    t_reset_pending();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_snd);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule